// File: doc/BRIEF.md
# Multi-State Program Counter and Fetch Unit

This block holds the program counter of a small processor front end and turns it into word-wide memory reads and a stream of instructions. It runs in one of three instruction states. The full-word state gives 32-bit instructions. The compact state gives 16-bit instructions. The bytecode state gives 8-bit instructions. Each state forces its own alignment on the counter, and the counter steps by the size of one instruction each time an instruction is consumed.

Memory is always read one aligned 32-bit word at a time. The word is kept in a single buffer, and the counter's low bits pick the halfword or byte lane out of that buffer. A new read is issued only after the last instruction that the word holds has been consumed. In the bytecode state, one read therefore serves four instructions. In the compact state, one read serves two.

A branch load sets a new target and a new state at the same moment. It flushes the buffer, and any read still in flight is dropped when its response arrives.

Top module: `pc_fetch_unit`

## Requirements
- R1: After reset the counter is 0, the state is full-word, no instruction is valid, and a fetch request for address 0 is raised.
- R2: The fetch address is the counter with bits [1:0] cleared. At most one read is outstanding. A raised request holds its address until `req_ready` is seen, unless a branch loads.
- R3: In the full-word state the instruction is the whole fetched word, the counter advances by 4 per consumed instruction, and counter bits [1:0] stay 0.
- R4: In the compact state counter bit 0 stays 0. The instruction is bits [31:16] of the word when counter bit 1 is 1, and bits [15:0] when it is 0. It is zero-extended, and the counter advances by 2.
- R5: In the bytecode state the instruction is byte lane k (bits 8k+7..8k) of the word, where k is counter bits [1:0]. It is zero-extended, and the counter advances by 1.
- R6: A new read is raised only once the last instruction held by the buffered word has been consumed. Consuming 7 bytes from address 0x301 onward takes exactly 2 reads.
- R7: A branch load sets the state from `mode_sel` (0 full-word, 1 compact, 2 bytecode, 3 full-word) and sets the counter to `br_target` aligned for that state. It discards the buffered word and drops the response of any read already in flight.
- R8: While `ins_valid` is high and `ins_ready` is low, and no branch loads, the instruction, its address and its valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | State taken at a branch load |
| br_valid | input | 1 | Branch load strobe |
| br_target | input | 32 | Branch target address |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Word-aligned fetch address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data word |
| ins_valid | output | 1 | Instruction valid |
| ins_ready | input | 1 | Consumer takes the instruction |
| ins_data | output | 32 | Instruction, zero-extended |
| ins_pc | output | 32 | Address of the instruction |

## Verification
Every output comes straight from registers, so a handshake decided before an edge shows at the outputs one cycle later. A response taken at an edge makes `ins_valid` high right after that edge. A consume or a branch moves `ins_pc` at that same edge. The bench sets its inputs on the falling edge and reads the outputs 1 ns later. It updates its reference counter, state and outstanding-read record in the order the edge will apply them: first check the consumed instruction, then step the counter, and let a branch override the step. Every instruction delivered and every request address is compared against that model, so each result is checked in the exact cycle it is due.

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          br_valid,
  input  logic [AW-1:0] br_target,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_data,
  output logic          ins_valid,
  input  logic          ins_ready,
  output logic [31:0]   ins_data,
  output logic [AW-1:0] ins_pc
);
  localparam logic [1:0] ST_W = 2'd0;
  localparam logic [1:0] ST_H = 2'd1;
  localparam logic [1:0] ST_B = 2'd2;

  logic [AW-1:0] pc;
  logic [1:0]    st;
  logic          buf_vld, pend, stale;
  logic [31:0]   word_q;

  function automatic logic [AW-1:0] align_pc(input logic [AW-1:0] a, input logic [1:0] s);
    case (s)
      ST_W:    return {a[AW-1:2], 2'b00};
      ST_H:    return {a[AW-1:1], 1'b0};
      default: return a;
    endcase
  endfunction

  wire [1:0] new_st  = (mode_sel == 2'd3) ? ST_W : mode_sel;
  wire       accept  = req_valid & req_ready;
  wire       take    = pend & rsp_valid;
  wire       consume = ins_valid & ins_ready;
  wire       last    = (st == ST_W) || (st == ST_H && pc[1]) || (st == ST_B && pc[1:0] == 2'b11);
  wire [AW-1:0] inc  = (st == ST_W) ? AW'(4) : (st == ST_H) ? AW'(2) : AW'(1);
  wire       pend_nx = accept ? 1'b1 : (take ? 1'b0 : pend);

  logic [31:0] lane;
  assign lane = word_q >> {pc[1:0], 3'b000};

  assign req_valid = !buf_vld && !pend;
  assign req_addr  = {pc[AW-1:2], 2'b00};
  assign ins_valid = buf_vld;
  assign ins_pc    = pc;

  always_comb begin
    case (st)
      ST_H:    ins_data = {16'h0, pc[1] ? word_q[31:16] : word_q[15:0]};
      ST_B:    ins_data = {24'h0, lane[7:0]};
      default: ins_data = word_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      st      <= ST_W;
      buf_vld <= 1'b0;
      pend    <= 1'b0;
      stale   <= 1'b0;
      word_q  <= '0;
    end else begin
      pend <= pend_nx;
      if (br_valid) begin
        pc      <= align_pc(br_target, new_st);
        st      <= new_st;
        buf_vld <= 1'b0;
        stale   <= pend_nx;
      end else begin
        if (take) stale <= 1'b0;
        if (take && !stale) begin
          buf_vld <= 1'b1;
          word_q  <= rsp_data;
        end else if (consume && last) begin
          buf_vld <= 1'b0;
        end
        if (consume) pc <= pc + inc;
      end
    end
  end

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_W |-> pc[1:0] == 2'b00); // R3
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_H |-> pc[0] == 1'b0); // R4
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    consume && st == ST_B && !br_valid |=> pc == $past(pc) + AW'(1)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !br_valid |=> req_valid && $stable(req_addr)); // R2
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !(consume && last) && !br_valid |=> !req_valid); // R6
  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> pc[AW-1:2] == $past(br_target[AW-1:2]) && !ins_valid); // R7
  AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready && !br_valid |=> ins_valid && $stable(ins_pc) && $stable(ins_data)); // R8
endmodule

// File: tb/sim_pc_fetch_unit.sv
module sim_pc_fetch_unit;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 0;
  logic br_valid = 0, req_ready = 0, rsp_valid = 0, ins_ready = 0;
  logic [31:0] br_target = 0, rsp_data = 0;
  logic req_valid, ins_valid;
  logic [31:0] req_addr, ins_data, ins_pc;

  pc_fetch_unit u0 (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .br_valid(br_valid),
    .br_target(br_target), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .ins_pc(ins_pc));

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0, fetches = 0, consumed = 0;
  logic [31:0] exp_pc = 0;
  logic [1:0]  exp_st = 0;
  bit          have_out = 0;
  int          cnt = 0;
  logic [31:0] out_addr = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A3C_C3A5;
  endfunction

  function automatic logic [1:0] map_st(input logic [1:0] s);
    return (s == 2'd3) ? 2'd0 : s;
  endfunction

  function automatic logic [31:0] align(input logic [31:0] a, input logic [1:0] s);
    if (s == 2'd0) return a & ~32'h3;
    if (s == 2'd1) return a & ~32'h1;
    return a;
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] p, input logic [1:0] s);
    logic [31:0] w = memf({p[31:2], 2'b00});
    if (s == 2'd0) return w;
    if (s == 2'd1) return p[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    return (w >> (8 * p[1:0])) & 32'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit ir, input bit rr, input bit bv, input logic [31:0] bt, input logic [1:0] bs);
    bit rv;
    ins_ready = ir; req_ready = rr; br_valid = bv; br_target = bt; mode_sel = bs;
    rv = have_out && cnt == 0;
    rsp_valid = rv;
    rsp_data = rv ? memf(out_addr) : $urandom;
    #1;
    if (req_valid) chk(req_addr == (exp_pc & ~32'h3), "R2 req_addr", req_addr, exp_pc & ~32'h3);
    if (ins_valid && ir) begin
      chk(ins_pc == exp_pc, "R3/R4/R5 ins_pc", ins_pc, exp_pc);
      chk(ins_data == exp_data(exp_pc, exp_st), "R3/R4/R5 ins_data", ins_data, exp_data(exp_pc, exp_st));
      exp_pc = exp_pc + ((exp_st == 0) ? 4 : (exp_st == 1) ? 2 : 1);
      consumed++;
    end
    if (rv) have_out = 0;
    else if (have_out) cnt--;
    if (req_valid && rr) begin
      have_out = 1; out_addr = req_addr; cnt = $urandom_range(0, 2); fetches++;
    end
    if (bv) begin
      exp_st = map_st(bs);
      exp_pc = align(bt, exp_st);
    end
    @(negedge clk);
  endtask

  task automatic run_until_consumed(input int n);
    int start = consumed;
    for (int i = 0; i < 400 && consumed - start < n; i++) step(1, 1, 0, 0, 0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk(ins_valid == 0, "R1 ins_valid in reset", 32'(ins_valid), 0);
    rst_n = 1;
    #1;
    chk(req_valid == 1, "R1 req_valid", 32'(req_valid), 1);
    chk(req_addr == 0, "R1 req_addr", req_addr, 0);
    chk(ins_valid == 0, "R1 ins_valid", 32'(ins_valid), 0);
    @(negedge clk);

    run_until_consumed(12);
    chk(exp_pc == 32'd48, "R3 word stride", exp_pc, 48);

    step(0, 1, 1, 32'h103, 2'd3);
    run_until_consumed(3);
    chk(exp_pc == 32'h10C, "R7 word target aligned", exp_pc, 32'h10C);

    step(0, 1, 1, 32'h207, 2'd1);
    run_until_consumed(5);
    chk(exp_pc == 32'h210, "R4 half stride", exp_pc, 32'h210);

    for (int i = 0; i < 400 && !ins_valid; i++) step(0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, 0, 0);
      chk(ins_valid == 1 && ins_pc == exp_pc, "R8 hold", ins_pc, exp_pc);
    end

    step(0, 1, 1, 32'h301, 2'd2);
    fetches = 0;
    run_until_consumed(7);
    chk(fetches == 2, "R6 byte fetch count", fetches, 2);
    chk(exp_pc == 32'h308, "R5 byte stride", exp_pc, 32'h308);

    for (int i = 0; i < 400 && !req_valid; i++) step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 1, 1, 32'h402, 2'd1);
    run_until_consumed(4);
    chk(exp_pc == 32'h40A, "R7 stale read dropped", exp_pc, 32'h40A);

    for (int i = 0; i < 4000; i++) begin
      bit bv = ($urandom_range(0, 11) == 0);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, bv,
           $urandom, 2'($urandom_range(0, 3)));
    end
    finish_run;
  end
endmodule